// File: doc/BRIEF.md
# Word-Size-Adaptive Transmit/Receive FIFO Pair

This block holds the transmit and receive queues of a serial port controller. Both queues share one fixed storage budget measured in bytes. The number of entries each queue can hold therefore depends on the selected word size: fewer entries when the words are wider. The register bus pushes words into the transmit queue and pops words from the receive queue. The shift engine pops from the transmit queue and pushes into the receive queue.

Each queue reports its fill level as an entry count. Each queue also raises an interrupt request, and a 2-bit mode field chooses the condition that raises it. Two sticky error flags are kept:
- receive overflow, set when a word arrives and the receive queue is full;
- transmit underrun, set when the shift engine pops an empty transmit queue in framed mode.

The word-size selection takes effect only while the port is disabled. Taking a new word size flushes both queues. Apart from that, the queues work whether the port is enabled or not.

Top module: `wafifo_pair`

## Requirements
- R1: Each queue holds 16 entries at 8-bit words, 8 entries at 16-bit words and 4 entries at 32-bit words. The level outputs are 5-bit entry counts that start at 0 after reset, and both error flags start cleared.
- R2: Word size code 0 selects 8-bit, 1 selects 16-bit and 2 selects 32-bit. Code 3 behaves as 32-bit. Stored words keep only the low bits of the selected width, and the upper bits read as zero.
- R3: Both queues return words in the order they were accepted.
- R4: The receive interrupt mode selects the condition that raises `rx_irq`: 0 when the queue is empty, 1 when it is not empty, 2 when the level is at least half the depth, 3 when the queue is full.
- R5: The transmit interrupt mode selects the condition that raises `tx_irq`: 0 when the queue is empty and `sh_busy` is low, 1 when the queue is empty, 2 when at least half the depth is free, 3 when at least one entry is free.
- R6: A receive push into a full receive queue sets the sticky `rx_ovf` flag. The pushed word is dropped and the stored words are kept. A pulse on `rx_ovf_clr` clears the flag.
- R7: A transmit pop from an empty transmit queue sets the sticky `tx_udr` flag when `framed` is high. When `framed` is low the pop has no effect. A pulse on `tx_udr_clr` clears the flag.
- R8: While `enable` is low, a new `wsize` value is taken on the next clock edge and both queues are flushed to level 0. While `enable` is high, a change of `wsize` is ignored.
- R9: A bus push into a full transmit queue is ignored, and so is a bus pop from an empty receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enabled; while high, changes of `wsize` are ignored |
| framed | input | 1 | Framed mode; an empty transmit pop counts as an underrun |
| wsize | input | 2 | Word size code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| rx_mode | input | 2 | Receive interrupt condition select |
| tx_mode | input | 2 | Transmit interrupt condition select |
| bus_tx_push | input | 1 | Bus writes a word into the transmit queue |
| bus_tx_data | input | 32 | Word written by the bus |
| bus_rx_pop | input | 1 | Bus removes the head word of the receive queue |
| bus_rx_data | output | 32 | Head word of the receive queue |
| sh_tx_pop | input | 1 | Shift engine removes the head word of the transmit queue |
| sh_tx_data | output | 32 | Head word of the transmit queue |
| sh_rx_push | input | 1 | Shift engine delivers a received word |
| sh_rx_data | input | 32 | Word delivered by the shift engine |
| sh_busy | input | 1 | Shift engine is still shifting a word |
| rx_ovf_clr | input | 1 | Clears the receive overflow flag |
| tx_udr_clr | input | 1 | Clears the transmit underrun flag |
| tx_level | output | 5 | Transmit queue entry count |
| rx_level | output | 5 | Receive queue entry count |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| tx_udr | output | 1 | Sticky transmit underrun flag |

## Verification
Each queue is filled to exactly its depth at each of the four word-size codes, with words whose upper bits are set. This separates a correct depth and mask from an off-by-one wrap or a missing zero-extension. One push beyond full on each side shows whether the extra word is dropped or overwrites stored data. A readback in order then catches any pointer wrap that is wrong for the current depth.

The interrupt modes are checked at levels just below and at the half-depth and full boundaries. Transmit mode 0 is also toggled with `sh_busy`, which tells the empty-and-idle condition apart from the plain empty one. Pops from an empty transmit queue are repeated with and without framing. Word-size changes are applied both while enabled and while disabled, to confirm that only the disabled case flushes the queues.

// File: rtl/wafifo_pkg.sv
package wafifo_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      WS_8  = 2'd0,
      WS_16 = 2'd1,
      WS_32 = 2'd2,
      WS_RS = 2'd3
   } wsize_e;

   function automatic logic [WORD_W-1:0] word_mask(input logic [1:0] ws);
      case (ws)
         WS_8:    word_mask = WORD_W'(32'h0000_00FF);
         WS_16:   word_mask = WORD_W'(32'h0000_FFFF);
         default: word_mask = '1;
      endcase
   endfunction

   function automatic int unsigned size_shift(input logic [1:0] ws);
      case (ws)
         WS_8:    size_shift = 0;
         WS_16:   size_shift = 1;
         default: size_shift = 2;
      endcase
   endfunction
endpackage

// File: rtl/wafifo_queue.sv
module wafifo_queue #(
   parameter int CAP_BYTES = 16,
   parameter int DATA_W    = 32,
   parameter int LVL_W     = $clog2(CAP_BYTES + 1),
   parameter int PTR_W     = $clog2(CAP_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [LVL_W-1:0]  depth,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty
);
   logic [DATA_W-1:0] mem [CAP_BYTES];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              do_push, do_pop;

   assign full    = (level == depth);
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                             input logic [LVL_W-1:0] d);
      if (LVL_W'(p) == d - LVL_W'(1)) step = '0;
      else                            step = p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= step(wr_ptr, depth);
         if (do_pop)  rd_ptr <= step(rd_ptr, depth);
         case ({do_push, do_pop})
            2'b10:   level <= level + LVL_W'(1);
            2'b01:   level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   // Level never exceeds the current depth (R1)
   assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= depth);
   // A push into a full queue leaves the stored count untouched (R6, R9)
   assert_full_push_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push && full && !pop && !flush |=> $stable(level));
   // Flush empties the queue on the next edge (R8)
   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> level == '0);
endmodule

// File: rtl/wafifo_thresh.sv
module wafifo_thresh #(
   parameter int LVL_W = 5,
   parameter bit IS_TX = 1'b0
) (
   input  logic [1:0]       mode,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] depth,
   input  logic             idle,
   output logic             irq
);
   logic [LVL_W-1:0] half;
   logic [LVL_W-1:0] room;

   assign half = depth >> 1;
   assign room = depth - level;

   generate
      if (IS_TX) begin : g_tx
         always_comb begin
            case (mode)
               2'd0:    irq = (level == '0) && idle;
               2'd1:    irq = (level == '0);
               2'd2:    irq = (room >= half);
               default: irq = (level < depth);
            endcase
         end
      end else begin : g_rx
         always_comb begin
            case (mode)
               2'd0:    irq = (level == '0);
               2'd1:    irq = (level != '0);
               2'd2:    irq = (level >= half);
               default: irq = (level == depth);
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/wafifo_pair.sv
module wafifo_pair
   import wafifo_pkg::*;
#(
   parameter int CAP_BYTES = 16,
   parameter int LVL_W     = $clog2(CAP_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              framed,
   input  logic [1:0]        wsize,
   input  logic [1:0]        rx_mode,
   input  logic [1:0]        tx_mode,
   input  logic              bus_tx_push,
   input  logic [WORD_W-1:0] bus_tx_data,
   input  logic              bus_rx_pop,
   output logic [WORD_W-1:0] bus_rx_data,
   input  logic              sh_tx_pop,
   output logic [WORD_W-1:0] sh_tx_data,
   input  logic              sh_rx_push,
   input  logic [WORD_W-1:0] sh_rx_data,
   input  logic              sh_busy,
   input  logic              rx_ovf_clr,
   input  logic              tx_udr_clr,
   output logic [LVL_W-1:0]  tx_level,
   output logic [LVL_W-1:0]  rx_level,
   output logic              tx_irq,
   output logic              rx_irq,
   output logic              rx_ovf,
   output logic              tx_udr
);
   localparam int PTR_W = $clog2(CAP_BYTES);

   if (CAP_BYTES < 8 || (CAP_BYTES % 4) != 0 || (CAP_BYTES & (CAP_BYTES - 1)) != 0) begin : g_bad_cap
      $error("CAP_BYTES must be a power of two of at least 8");
   end
   if (LVL_W < $clog2(CAP_BYTES + 1)) begin : g_bad_lvl
      $error("LVL_W too narrow for CAP_BYTES");
   end

   logic [1:0]        eff_ws;
   logic              flush;
   logic [LVL_W-1:0]  depth;
   logic [WORD_W-1:0] mask;
   logic              tx_full, tx_empty, rx_full, rx_empty;

   assign flush = !enable && (wsize != eff_ws);
   assign depth = LVL_W'(CAP_BYTES >> size_shift(eff_ws));
   assign mask  = word_mask(eff_ws);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      eff_ws <= WS_8;
      else if (flush)  eff_ws <= wsize;
   end

   wafifo_queue #(.CAP_BYTES(CAP_BYTES), .DATA_W(WORD_W), .LVL_W(LVL_W), .PTR_W(PTR_W)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .depth(depth),
      .push(bus_tx_push), .din(bus_tx_data & mask),
      .pop(sh_tx_pop), .dout(sh_tx_data),
      .level(tx_level), .full(tx_full), .empty(tx_empty)
   );

   wafifo_queue #(.CAP_BYTES(CAP_BYTES), .DATA_W(WORD_W), .LVL_W(LVL_W), .PTR_W(PTR_W)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .depth(depth),
      .push(sh_rx_push), .din(sh_rx_data & mask),
      .pop(bus_rx_pop), .dout(bus_rx_data),
      .level(rx_level), .full(rx_full), .empty(rx_empty)
   );

   wafifo_thresh #(.LVL_W(LVL_W), .IS_TX(1'b1)) u_tx_thr (
      .mode(tx_mode), .level(tx_level), .depth(depth), .idle(!sh_busy), .irq(tx_irq)
   );

   wafifo_thresh #(.LVL_W(LVL_W), .IS_TX(1'b0)) u_rx_thr (
      .mode(rx_mode), .level(rx_level), .depth(depth), .idle(1'b1), .irq(rx_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ovf <= 1'b0;
         tx_udr <= 1'b0;
      end else begin
         if (sh_rx_push && rx_full)            rx_ovf <= 1'b1;
         else if (rx_ovf_clr)                  rx_ovf <= 1'b0;
         if (sh_tx_pop && tx_empty && framed)  tx_udr <= 1'b1;
         else if (tx_udr_clr)                  tx_udr <= 1'b0;
      end
   end

   // Receive into a full queue raises the overflow flag (R6)
   assert_ovf_on_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sh_rx_push && rx_full |=> rx_ovf);
   // Without framing an empty pop never raises underrun (R7)
   assert_no_udr_unframed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !framed && !tx_udr |=> !tx_udr);
   // The effective word size stays put while enabled (R8)
   assert_ws_hold_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> $stable(eff_ws));
endmodule

// File: tb/wafifo_pair_tb.sv
module wafifo_pair_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0, framed = 1'b0, sh_busy = 1'b0;
   logic [1:0]  wsize = 2'd0, rx_mode = 2'd0, tx_mode = 2'd0;
   logic        bus_tx_push = 1'b0, bus_rx_pop = 1'b0, sh_tx_pop = 1'b0, sh_rx_push = 1'b0;
   logic [31:0] bus_tx_data = '0, sh_rx_data = '0;
   logic        rx_ovf_clr = 1'b0, tx_udr_clr = 1'b0;
   logic [31:0] bus_rx_data, sh_tx_data;
   logic [4:0]  tx_level, rx_level;
   logic        tx_irq, rx_irq, rx_ovf, tx_udr;

   int compared = 0, mismatched = 0;
   int cur_ws = 0;
   bit done = 1'b0;
   logic [31:0] exp_tx[$];
   logic [31:0] exp_rx[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   wafifo_pair dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .framed(framed), .wsize(wsize),
      .rx_mode(rx_mode), .tx_mode(tx_mode),
      .bus_tx_push(bus_tx_push), .bus_tx_data(bus_tx_data),
      .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
      .sh_tx_pop(sh_tx_pop), .sh_tx_data(sh_tx_data),
      .sh_rx_push(sh_rx_push), .sh_rx_data(sh_rx_data), .sh_busy(sh_busy),
      .rx_ovf_clr(rx_ovf_clr), .tx_udr_clr(tx_udr_clr),
      .tx_level(tx_level), .rx_level(rx_level), .tx_irq(tx_irq), .rx_irq(rx_irq),
      .rx_ovf(rx_ovf), .tx_udr(tx_udr)
   );

   function automatic int bdepth(input int ws);
      return 16 >> ((ws >= 2) ? 2 : ws);
   endfunction
   function automatic logic [31:0] bmask(input int ws);
      return (ws == 0) ? 32'hFF : (ws == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: bus push into transmit queue, scoreboard records accepted word
   task automatic tx_push(input logic [31:0] d);
      @(negedge clk);
      bus_tx_push = 1'b1; bus_tx_data = d;
      if (exp_tx.size() < bdepth(cur_ws)) exp_tx.push_back(d & bmask(cur_ws));
      @(negedge clk);
      bus_tx_push = 1'b0;
   endtask

   task automatic rx_push(input logic [31:0] d);
      @(negedge clk);
      sh_rx_push = 1'b1; sh_rx_data = d;
      if (exp_rx.size() < bdepth(cur_ws)) exp_rx.push_back(d & bmask(cur_ws));
      @(negedge clk);
      sh_rx_push = 1'b0;
   endtask

   // monitor: compares the head word against the scoreboard as it leaves
   task automatic tx_pop_cmp(input string req);
      @(negedge clk);
      check(req, sh_tx_data, exp_tx.pop_front());
      sh_tx_pop = 1'b1;
      @(negedge clk);
      sh_tx_pop = 1'b0;
   endtask

   task automatic rx_pop_cmp(input string req);
      @(negedge clk);
      check(req, bus_rx_data, exp_rx.pop_front());
      bus_rx_pop = 1'b1;
      @(negedge clk);
      bus_rx_pop = 1'b0;
   endtask

   task automatic tx_pop_empty();
      @(negedge clk); sh_tx_pop = 1'b1;
      @(negedge clk); sh_tx_pop = 1'b0;
   endtask

   task automatic set_ws(input int ws);
      @(negedge clk); enable = 1'b0; wsize = 2'(ws);
      @(negedge clk); enable = 1'b1; cur_ws = ws;
      exp_tx.delete(); exp_rx.delete();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 tx_level reset", 32'(tx_level), 0);
      check("R1 rx_level reset", 32'(rx_level), 0);
      check("R1 flags reset", {30'd0, rx_ovf, tx_udr}, 0);
      check("R4 rx mode0 empty", 32'(rx_irq), 1);
      rst_n = 1'b1;
      enable = 1'b1;

      // R1 R2 R3 R9: 8-bit words, 16 entries, one extra push dropped
      tx_mode = 2'd3;
      for (int i = 0; i < 17; i++) tx_push(32'hDEAD_0010 + 32'(i));
      @(negedge clk);
      check("R1 tx depth 8-bit", 32'(tx_level), 16);
      check("R5 tx mode3 full", 32'(tx_irq), 0);
      for (int i = 0; i < 16; i++) tx_pop_cmp("R3 R2 R9 tx order 8-bit");
      @(negedge clk);
      check("R1 tx drained", 32'(tx_level), 0);

      // R5 empty modes with and without shifter activity
      tx_mode = 2'd0; sh_busy = 1'b1; @(negedge clk);
      check("R5 mode0 busy", 32'(tx_irq), 0);
      sh_busy = 1'b0; @(negedge clk);
      check("R5 mode0 idle", 32'(tx_irq), 1);
      tx_mode = 2'd1; sh_busy = 1'b1; @(negedge clk);
      check("R5 mode1 empty", 32'(tx_irq), 1);
      sh_busy = 1'b0;

      // R7 underrun only in framed mode
      tx_pop_empty(); @(negedge clk);
      check("R7 unframed no udr", 32'(tx_udr), 0);
      framed = 1'b1; tx_pop_empty(); @(negedge clk);
      check("R7 framed udr", 32'(tx_udr), 1);
      framed = 1'b0; @(negedge clk); tx_udr_clr = 1'b1; @(negedge clk); tx_udr_clr = 1'b0;
      check("R7 udr cleared", 32'(tx_udr), 0);

      // R4 R6 receive thresholds and overflow
      rx_mode = 2'd2;
      for (int i = 0; i < 7; i++) rx_push(32'hBEEF_0040 + 32'(i));
      @(negedge clk);
      check("R4 mode2 below half", 32'(rx_irq), 0);
      rx_push(32'h47);
      @(negedge clk);
      check("R4 mode2 at half", 32'(rx_irq), 1);
      for (int i = 8; i < 16; i++) rx_push(32'h40 + 32'(i));
      rx_mode = 2'd3; @(negedge clk);
      check("R4 mode3 full", 32'(rx_irq), 1);
      check("R6 no ovf yet", 32'(rx_ovf), 0);
      rx_push(32'h0000_00EE);
      @(negedge clk);
      check("R6 ovf set", 32'(rx_ovf), 1);
      check("R6 level kept", 32'(rx_level), 16);
      rx_mode = 2'd1;
      for (int i = 0; i < 16; i++) rx_pop_cmp("R6 R3 rx order after overflow");
      @(negedge clk);
      check("R4 mode1 empty", 32'(rx_irq), 0);
      bus_rx_pop = 1'b1; @(negedge clk); bus_rx_pop = 1'b0; @(negedge clk);
      check("R9 pop empty rx ignored", 32'(rx_level), 0);
      rx_ovf_clr = 1'b1; @(negedge clk); rx_ovf_clr = 1'b0;
      check("R6 ovf cleared", 32'(rx_ovf), 0);

      // R8 word size change while enabled is ignored, disabled flushes
      for (int i = 0; i < 3; i++) tx_push(32'h1234_5600 + 32'(i));
      wsize = 2'd1; @(negedge clk); @(negedge clk);
      check("R8 enabled change no flush", 32'(tx_level), 3);
      enable = 1'b0; @(negedge clk);
      check("R8 disabled flush", 32'(tx_level), 0);
      enable = 1'b1; cur_ws = 1; exp_tx.delete();

      // R1 R2 16-bit
      for (int i = 0; i < 9; i++) tx_push(32'hCAFE_1000 + 32'(i));
      @(negedge clk);
      check("R1 tx depth 16-bit", 32'(tx_level), 8);
      for (int i = 0; i < 8; i++) tx_pop_cmp("R2 R3 tx 16-bit");

      // R1 R2 R5 32-bit
      set_ws(2);
      tx_mode = 2'd2;
      tx_push(32'hA1A2_A3A4); tx_push(32'hB1B2_B3B4);
      @(negedge clk);
      check("R5 mode2 half free", 32'(tx_irq), 1);
      tx_push(32'hC1C2_C3C4);
      @(negedge clk);
      check("R5 mode2 below half free", 32'(tx_irq), 0);
      tx_push(32'hD1D2_D3D4); tx_push(32'hE1E2_E3E4);
      @(negedge clk);
      check("R1 tx depth 32-bit", 32'(tx_level), 4);
      for (int i = 0; i < 4; i++) tx_pop_cmp("R2 R3 tx 32-bit");

      // R2 code 3 acts as 32-bit
      set_ws(3);
      for (int i = 0; i < 5; i++) rx_push(32'hF00D_0000 + 32'(i));
      @(negedge clk);
      check("R2 code3 depth", 32'(rx_level), 4);
      for (int i = 0; i < 4; i++) rx_pop_cmp("R2 code3 rx data");

      finish_run();
   end
endmodule